// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block collects interrupt requests from a large set of GPIO lines, arranged in groups of sixteen, and merges them into one interrupt output. Every line has a programmable trigger condition (a level or an edge), a mask bit and a pending bit. The pending bits of two groups share one 32-bit word, and so do their mask bits and trigger fields. One trigger field is shared by four neighbouring lines.

The interrupt handler reads one service word and gets the group and line of the pending, unmasked request with the highest priority. It then clears that request by writing a one to its pending bit, so it never has to scan the pending words. Configuration and status go through a simple 32-bit register bus. Writes take effect on the clock edge. Read data is combinational from the address.

Register layout, with `w` the word index from 0 to NUM_WORDS-1:
- Trigger words are at `0x00 + 4*w`.
- Mask words are at `0x40 + 4*w`.
- Pending words are at `0x60 + 4*w`.
- The service word is at `0x84` and is read-only.

Line `n` sits in word `n/32`, at bit `n%32`. It belongs to group `n/16`.

Top module: `gint_ctrl`

## Requirements
- R1: After reset every trigger word reads 0, every mask word reads 0xFFFFFFFF, every pending word reads 0, the service word reads 0 and `irq_o` is low.
- R2: A write to a trigger word (`0x00+4w`) or to a mask word (`0x40+4w`) stores the full 32 bits, and a read returns them. These words change only on such a write.
- R3: Line `n` uses the 4-bit trigger field at flat bit offset `4*(n/4)`. Within word `n/32` this is bit `4*((n%32)/4)`, so one field serves four consecutive lines.
- R4: Trigger code 0 (low level) and code 1 (high level) set the pending bit on every cycle the synchronised input holds the active level. A clear issued while the level is still active has no lasting effect, because the bit is set again.
- R5: Trigger code 2 sets the pending bit on a 1→0 transition, code 4 on a 0→1 transition, and code 6 on either transition. A steady input, or a transition of the wrong direction, sets nothing.
- R6: Writing to a pending word clears the bits written as 1 and leaves the bits written as 0 unchanged. If a set and a clear hit the same bit in the same cycle, the set wins.
- R7: A mask bit of 1 keeps its line out of `irq_o` and out of the service word. The pending bit still records the event, and it takes part again as soon as the mask bit returns to 0.
- R8: The service word (`0x84`) holds group number + 1 in bits 7:4 and the line within that group in bits 3:0. Its upper bits are 0. It reads 0 when no pending, unmasked line exists. Writes to it are ignored.
- R9: If several lines are pending and unmasked, the service word reports the one with the lowest global index.
- R10: `irq_o` is high exactly when at least one pending bit has its mask bit at 0.
- R11: Each input passes through a two-flop synchroniser. An input change driven between clock edges first shows in its pending bit after the third rising edge that follows it.
- R12: Writes to addresses that hold no register change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_i | input | 32*NUM_WORDS (160) | Asynchronous GPIO interrupt lines, global index = bit number |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A corrupted pending or mask bit is visible through the service word on the same cycle. Such a fault also flips `irq_o`, or moves the reported group or line away from the lowest live index. A mis-decoded trigger field or a synchroniser stage too many or too few appears as a pending bit that sets in the wrong case. It also shows as a bit that sets on a rising edge other than the third after the input change. A wrong clear path is caught because the bit still reads back as set, or reads back as cleared, one cycle after the write.

// File: rtl/gint_pkg.sv
package gint_pkg;

    localparam int GRP_LINES = 16;
    localparam int WORD_BITS = 32;

    // Decide whether one line raises its pending bit this cycle.
    // A code with bit 2 or bit 1 set selects edge detection:
    // bit 2 means rising, bit 1 means falling.
    // Otherwise bit 0 selects the active level: 1 is high, 0 is low.
    function automatic logic line_hit(input logic [3:0] code,
                                      input logic       cur,
                                      input logic       prev);
        logic rise;
        logic fall;
        rise = code[2] & cur & ~prev;
        fall = code[1] & ~cur & prev;
        if (code[2:1] != 2'b00)
            return rise | fall;
        else
            return code[0] ? cur : ~cur;
    endfunction

endpackage

// File: rtl/gint_sync.sv
module gint_sync #(
    parameter int  WIDTH   = 160,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stab;
        logic [WIDTH-1:0] old;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = din;
        s_d.stab = s_q.meta;
        s_d.old  = s_q.stab;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= {3*WIDTH{RST_VAL}};
        end else begin
            s_q <= s_d;
        end
    end

    assign cur  = s_q.stab;
    assign prev = s_q.old;

endmodule

// File: rtl/gint_detect.sv
module gint_detect #(
    parameter int LINES = 160
) (
    input  logic [LINES-1:0] ctrl,
    input  logic [LINES-1:0] cur,
    input  logic [LINES-1:0] prev,
    output logic [LINES-1:0] hit
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        // Four consecutive lines share one 4-bit field.
        localparam int FIELD_LSB = 4 * (i / 4);
        assign hit[i] = gint_pkg::line_hit(ctrl[FIELD_LSB +: 4], cur[i], prev[i]);
    end

endmodule

// File: rtl/gint_prio.sv
module gint_prio #(
    parameter int LINES = 160
) (
    input  logic [LINES-1:0] req,
    output logic [7:0]       svc
);

    localparam int IW = $clog2(LINES);

    logic          found;
    logic [IW-1:0] idx;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        // Walk downwards so that the lowest set index is written last.
        for (int i = LINES - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    always_comb begin
        svc = 8'h00;
        if (found) begin
            svc[7:4] = 4'(idx >> 4) + 4'd1;
            svc[3:0] = idx[3:0];
        end
    end

endmodule

// File: rtl/gint_ctrl.sv
module gint_ctrl #(
    parameter int NUM_WORDS = 5,
    parameter int ADDR_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [32*NUM_WORDS-1:0] gpio_i,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic                    irq_o
);

    localparam int NUM_LINES = gint_pkg::WORD_BITS * NUM_WORDS;
    localparam int NUM_GRP   = NUM_LINES / gint_pkg::GRP_LINES;
    localparam int CTRL_BASE = 'h00;
    localparam int MASK_BASE = 'h40;
    localparam int PEND_BASE = 'h60;
    localparam int SVC_ADDR  = 'h84;

    typedef struct packed {
        logic [NUM_LINES-1:0] ctrl;
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] pend;
    } regs_t;

    regs_t st_d, st_q;

    logic [NUM_LINES-1:0] sync_cur;
    logic [NUM_LINES-1:0] sync_prev;
    logic [NUM_LINES-1:0] hit;
    logic [NUM_LINES-1:0] clr;
    logic [NUM_LINES-1:0] live;
    logic [7:0]           svc_w;

    // The reset level is inactive for the reset trigger code (low level).
    gint_sync #(.WIDTH(NUM_LINES), .RST_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (gpio_i),
        .cur  (sync_cur),
        .prev (sync_prev)
    );

    gint_detect #(.LINES(NUM_LINES)) u_detect (
        .ctrl (st_q.ctrl),
        .cur  (sync_cur),
        .prev (sync_prev),
        .hit  (hit)
    );

    assign live = st_q.pend & ~st_q.mask;

    gint_prio #(.LINES(NUM_LINES)) u_prio (
        .req (live),
        .svc (svc_w)
    );

    always_comb begin
        st_d = st_q;
        clr  = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (bus_we && bus_addr == ADDR_W'(CTRL_BASE + 4 * w))
                st_d.ctrl[32*w +: 32] = bus_wdata;
            if (bus_we && bus_addr == ADDR_W'(MASK_BASE + 4 * w))
                st_d.mask[32*w +: 32] = bus_wdata;
            if (bus_we && bus_addr == ADDR_W'(PEND_BASE + 4 * w))
                clr[32*w +: 32] = bus_wdata;
        end
        // A set in the same cycle wins over a clear.
        st_d.pend = (st_q.pend & ~clr) | hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ctrl <= '0;
            st_q.mask <= '1;
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = 32'h0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (bus_addr == ADDR_W'(CTRL_BASE + 4 * w))
                bus_rdata = st_q.ctrl[32*w +: 32];
            if (bus_addr == ADDR_W'(MASK_BASE + 4 * w))
                bus_rdata = st_q.mask[32*w +: 32];
            if (bus_addr == ADDR_W'(PEND_BASE + 4 * w))
                bus_rdata = st_q.pend[32*w +: 32];
        end
        if (bus_addr == ADDR_W'(SVC_ADDR))
            bus_rdata = {24'h0, svc_w};
    end

    assign irq_o = |live;

    if (NUM_GRP > 15) begin : g_bad_cfg
        initial $error("group count does not fit the 4-bit service field");
    end

endmodule

// File: rtl/gint_ctrl_chk.sv
module gint_ctrl_chk #(
    parameter int NL = 160
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_we,
    input logic          irq_o,
    input logic [7:0]    svc,
    input logic [NL-1:0] ctrl,
    input logic [NL-1:0] mask,
    input logic [NL-1:0] pend
);

    localparam int IW = $clog2(NL) + 1;

    logic [IW-1:0] idx;
    logic [NL-1:0] below;

    assign idx   = IW'((int'(svc[7:4]) - 1) * 16 + int'(svc[3:0]));
    assign below = ({{(NL-1){1'b0}}, 1'b1} << idx) - 1'b1;

    // R1: the cycle after reset is held, no request is raised.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !irq_o)
        else $error("a_r1_quiet_after_reset");

    // R2: trigger and mask words hold their value without a write.
    a_r2_cfg_holds: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> ($stable(ctrl) && $stable(mask)))
        else $error("a_r2_cfg_holds");

    // R10: the combined output agrees with the service encoder.
    a_r10_irq_matches_svc: assert property (@(posedge clk) disable iff (rst)
        irq_o == (svc[7:4] != 4'd0))
        else $error("a_r10_irq_matches_svc");

    // R8: a reported line is pending and unmasked.
    a_r8_svc_points_live: assert property (@(posedge clk) disable iff (rst)
        (svc[7:4] != 4'd0) |-> (pend[idx] && !mask[idx]))
        else $error("a_r8_svc_points_live");

    // R9: no live line with a lower index than the reported one.
    a_r9_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        (svc[7:4] != 4'd0) |-> ((pend & ~mask & below) == '0))
        else $error("a_r9_lowest_wins");

endmodule

bind gint_ctrl gint_ctrl_chk #(.NL(NUM_LINES)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .bus_we (bus_we),
    .irq_o  (irq_o),
    .svc    (svc_w),
    .ctrl   (st_q.ctrl),
    .mask   (st_q.mask),
    .pend   (st_q.pend)
);

// File: tb/gint_ctrl_test.sv
module gint_ctrl_test;

    localparam int NW = 5;
    localparam int NL = 32 * NW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] gpio = '1;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_addr = 8'h0;
    logic [31:0]   bus_wdata = 32'h0;
    logic [31:0]   bus_rdata;
    logic          irq;

    int total = 0;
    int bad   = 0;
    logic [31:0] ctrl_m [NW];
    logic [31:0] rd;

    gint_ctrl #(.NUM_WORDS(NW)) uut (
        .clk       (clk),
        .rst       (rst),
        .gpio_i    (gpio),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq)
    );

    always #2 clk = ~clk;

    // Vector: {line[7:0], code[3:0], before, after, expected pending, pad}
    localparam logic [15:0] VEC [12] = '{
        {8'd0,   4'd4, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 rising seen
        {8'd5,   4'd4, 1'b1, 1'b0, 1'b0, 1'b0},  // R5 falling ignored by rise
        {8'd9,   4'd2, 1'b1, 1'b0, 1'b1, 1'b0},  // R5 falling seen
        {8'd13,  4'd2, 1'b0, 1'b1, 1'b0, 1'b0},  // R5 rising ignored by fall
        {8'd17,  4'd6, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 both, rise
        {8'd21,  4'd6, 1'b1, 1'b0, 1'b1, 1'b0},  // R5 both, fall
        {8'd37,  4'd1, 1'b0, 1'b1, 1'b1, 1'b0},  // R4 high level
        {8'd45,  4'd1, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 high level inactive
        {8'd66,  4'd0, 1'b1, 1'b0, 1'b1, 1'b0},  // R4 low level
        {8'd70,  4'd0, 1'b1, 1'b1, 1'b0, 1'b0},  // R4 low level inactive
        {8'd159, 4'd4, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 last line
        {8'd100, 4'd6, 1'b1, 1'b1, 1'b0, 1'b0}   // R5 steady input
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_code(input int line, input logic [3:0] code);
        int w;
        w = line / 32;
        ctrl_m[w][4*((line % 32) / 4) +: 4] = code;
        wr(8'(4 * w), ctrl_m[w]);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int w = 0; w < NW; w++) ctrl_m[w] = 32'h0;
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(5);

        // R1 reset state
        for (int w = 0; w < NW; w++) begin
            rdreg(8'(4 * w), rd);         check("R1 ctrl", rd, 32'h0);
            rdreg(8'(8'h40 + 4 * w), rd); check("R1 mask", rd, 32'hFFFFFFFF);
            rdreg(8'(8'h60 + 4 * w), rd); check("R1 pend", rd, 32'h0);
        end
        rdreg(8'h84, rd); check("R1 svc", rd, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // R2 readback
        wr(8'h44, 32'hA5A5_0F0F);
        rdreg(8'h44, rd); check("R2 mask readback", rd, 32'hA5A5_0F0F);
        wr(8'h44, 32'hFFFF_FFFF);
        wr(8'h10, 32'h1234_5678);
        rdreg(8'h10, rd); check("R2 ctrl readback", rd, 32'h1234_5678);
        wr(8'h10, 32'h0);

        // R12 unmapped and service writes
        wr(8'h84, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        rdreg(8'h84, rd); check("R12 svc unchanged", rd, 32'h0);
        rdreg(8'h00, rd); check("R12 ctrl unchanged", rd, 32'h0);
        rdreg(8'h60, rd); check("R12 pend unchanged", rd, 32'h0);

        // Vector table: R4, R5
        for (int v = 0; v < 12; v++) begin
            int line;
            int w;
            logic [3:0] code;
            line = int'(VEC[v][15:8]);
            code = VEC[v][7:4];
            w = line / 32;
            set_code(line, code);
            @(negedge clk); gpio[line] = VEC[v][3];
            wait_cyc(5);
            wr(8'(8'h60 + 4 * w), 32'h1 << (line % 32));
            @(negedge clk); gpio[line] = VEC[v][2];
            wait_cyc(6);
            rdreg(8'(8'h60 + 4 * w), rd);
            check(code[2:1] != 0 ? "R5 edge vector" : "R4 level vector",
                  {31'h0, rd[line % 32]}, {31'h0, VEC[v][1]});
        end

        // R6 write-one-to-clear; line 0 still pending from the table
        wr(8'h60, 32'h0);
        rdreg(8'h60, rd); check("R6 zero write keeps", {31'h0, rd[0]}, 32'h1);
        wr(8'h60, 32'h1);
        rdreg(8'h60, rd); check("R6 one write clears", {31'h0, rd[0]}, 32'h0);

        // R4 level sets again after a clear; line 37 high, input high
        wr(8'h64, 32'h1 << 5);
        rdreg(8'h64, rd); check("R4 level re-set", {31'h0, rd[5]}, 32'h1);
        @(negedge clk); gpio[37] = 1'b0;
        wait_cyc(5);
        wr(8'h64, 32'h1 << 5);
        wait_cyc(2);
        rdreg(8'h64, rd); check("R4 level released", {31'h0, rd[5]}, 32'h0);

        // R3 shared field: field of lines 24..27 drives line 26; line 28 not
        set_code(24, 4'd4);
        @(negedge clk); gpio[26] = 1'b0; gpio[28] = 1'b0;
        wait_cyc(5);
        wr(8'h60, 32'hFFFF_FFFF);
        @(negedge clk); gpio[26] = 1'b1;
        wait_cyc(6);
        rdreg(8'h60, rd); check("R3 shared field", {31'h0, rd[26]}, 32'h1);
        rdreg(8'h60, rd); check("R3 next field low level", {31'h0, rd[28]}, 32'h1);
        gpio[28] = 1'b1;

        // Rising everywhere, all inputs idle high, all pending cleared
        for (int w = 0; w < NW; w++) begin
            ctrl_m[w] = 32'h4444_4444;
            wr(8'(4 * w), ctrl_m[w]);
        end
        @(negedge clk); gpio = '1;
        wait_cyc(5);
        for (int w = 0; w < NW; w++) wr(8'(8'h60 + 4 * w), 32'hFFFF_FFFF);

        // R11 latency on line 60
        @(negedge clk); gpio[60] = 1'b0;
        wait_cyc(5);
        wr(8'h64, 32'hFFFF_FFFF);
        @(negedge clk); gpio[60] = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        rdreg(8'h64, rd); check("R11 not after two edges", {31'h0, rd[28]}, 32'h0);
        @(posedge clk); #1;
        rdreg(8'h64, rd); check("R11 set after third edge", {31'h0, rd[28]}, 32'h1);
        wr(8'h64, 32'hFFFF_FFFF);

        // R7..R10: events on lines 40 (group 2, line 8) and 150 (group 9, line 6)
        @(negedge clk); gpio[40] = 1'b0; gpio[150] = 1'b0;
        wait_cyc(5);
        for (int w = 0; w < NW; w++) wr(8'(8'h60 + 4 * w), 32'hFFFF_FFFF);
        @(negedge clk); gpio[40] = 1'b1; gpio[150] = 1'b1;
        wait_cyc(6);
        rdreg(8'h64, rd); check("R7 masked still pends", {31'h0, rd[8]}, 32'h1);
        rdreg(8'h84, rd); check("R7 masked svc empty", rd, 32'h0);
        check("R7 masked irq low", {31'h0, irq}, 32'h0);
        wr(8'h50, 32'hFFFF_FFFF & ~(32'h1 << 22));
        rdreg(8'h84, rd); check("R8 svc format group 10 line 6", rd, 32'h0000_00A6);
        check("R10 irq high", {31'h0, irq}, 32'h1);
        wr(8'h44, 32'hFFFF_FFFF & ~(32'h1 << 8));
        rdreg(8'h84, rd); check("R9 lowest index wins", rd, 32'h0000_0038);
        wr(8'h64, 32'h1 << 8);
        rdreg(8'h84, rd); check("R9 next after clear", rd, 32'h0000_00A6);
        wr(8'h70, 32'h1 << 22);
        rdreg(8'h84, rd); check("R8 svc empty", rd, 32'h0);
        check("R10 irq low", {31'h0, irq}, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule